// File: doc/BRIEF.md
# Three-Channel Microprogrammed PWM Ramp Engine

This block drives three pulse-width modulated outputs whose duty cycle is set by a small program per channel, not by a compare value that software writes. One free-running 8-bit counter is shared by all channels. It advances once per time-base tick, and each tick lasts `TICK_DIV` clock cycles. Each channel holds an 8-bit brightness level. The channel output is high while that level is at or above the shared counter. A blanking flag can hold the output low at any level.

Each channel has its own program memory of 16-bit words. A sequencer runs these words one by one. A ramp word moves the brightness one unit at a time, up or down, with a fixed number of ticks between steps. Other words force the output fully on or fully off, jump to a chosen word, or go back to word 0. The host loads a program through a byte-wide write port while the channel is stopped, then sets the channel's enable bit to run it.

Top module: `pwm_ramp_engine`

## Requirements
- R1: The shared counter counts 0x00 to 0xFF and wraps, advancing once every `TICK_DIV` clocks. While a channel is enabled and not blanked, its output is high when its brightness is greater than or equal to the counter. Over one 256-tick period the output is therefore high for brightness+1 ticks.
- R2: Write address 0 is the control register, and data bit c (c = 0, 1, 2) enables channel c. A cleared bit stops the channel, and the output is low from the second clock edge after the write. Setting the bit starts the program at word 0. The brightness keeps its earlier value, so relative ramps carry on from the last level.
- R3: A word with bit 15 clear that is neither 0x0000, 0x007F nor 0x00FF is a ramp. Bits 6:0 give the step count, and bit 7 gives the direction (0 = up, 1 = down). Each step changes the brightness by one and clears blanking. Steps saturate at 0x00 and 0xFF without wrapping. When the steps are used up, or if the count is 0, execution moves to the next word.
- R4: In a ramp word, bits 13:8 give the number of ticks per step, and a value of 0 acts as 1. Bit 14 multiplies that time by 512 (2^`PRESC_LOG2`).
- R5: A word with bits 15 and 13 both set jumps to the word address held in bits 5:0. A branch to its own address holds the channel there. The word 0x0000 returns execution to word 0.
- R6: The word 0x007F sets the brightness to 0x00 and blanks the output, so it stays low the whole time. The word 0x00FF sets the brightness to 0xFF and clears blanking, so it stays high the whole time.
- R7: Write address 1+c is the program port of channel c. Each word takes two byte writes, high byte first and then low byte. Successive pairs fill word 0, 1, 2 and so on, up to 64 words.
- R8: While a channel is enabled, writes to its program port have no effect, and its load pointer stays at word 0. A channel loaded afresh after being disabled starts filling at word 0.
- R9: After reset all channels are disabled, all outputs are low, and each brightness is 0x00 with no blanking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 = control, 1+c = program port of channel c |
| wr_data | input | 8 | Write data byte |
| pwm_out | output | 3 | Registered PWM outputs, one per channel |

## Verification
A control write takes effect at the clock edge that samples it. The registered output reflects the new enable one edge later, so the bench checks the stopped output low three cycles after the write. A ramp ends only after steps × step-time ticks plus one cycle to load the word. The bench therefore waits that many ticks, plus a margin, before it measures the duty. Brightness is observed only through the duty: the bench counts high cycles over exactly 256 × `TICK_DIV` clocks, which gives the level no matter where in the counter phase the window starts. In the prescale case the bench takes a measurement in the window before the first step and another after the second step.

// File: rtl/pwm_ramp_pkg.sv
package pwm_ramp_pkg;

  typedef enum logic [2:0] {
    OP_RESTART,
    OP_JUMP,
    OP_FORCE_OFF,
    OP_FORCE_ON,
    OP_RAMP,
    OP_SKIP
  } op_e;

  localparam logic [15:0] WORD_RESTART   = 16'h0000;
  localparam logic [15:0] WORD_FORCE_OFF = 16'h007F;
  localparam logic [15:0] WORD_FORCE_ON  = 16'h00FF;

  // Instruction class of one program word.
  function automatic op_e decode_op(input logic [15:0] w);
    op_e r;
    if (w == WORD_RESTART)          r = OP_RESTART;
    else if (w[15] && w[13])        r = OP_JUMP;
    else if (w == WORD_FORCE_OFF)   r = OP_FORCE_OFF;
    else if (w == WORD_FORCE_ON)    r = OP_FORCE_ON;
    else if (!w[15])                r = OP_RAMP;
    else                            r = OP_SKIP;
    return r;
  endfunction

  // One saturating brightness step.
  function automatic logic [7:0] sat_step(input logic [7:0] b, input logic down);
    logic [7:0] r;
    if (down) r = (b == 8'h00) ? 8'h00 : b - 8'd1;
    else      r = (b == 8'hFF) ? 8'hFF : b + 8'd1;
    return r;
  endfunction

  // Ticks between ramp steps for one ramp word.
  function automatic logic [15:0] step_ticks(input logic [15:0] w, input int presc_log2);
    logic [15:0] t;
    t = {10'd0, w[13:8]};
    if (t == 16'd0) t = 16'd1;
    if (w[14]) t = t << presc_log2;
    return t;
  endfunction

endpackage

// File: rtl/pwm_ramp_timebase.sv
module pwm_ramp_timebase #(
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       tick_o,
  output logic [7:0] cnt_o
);

  generate
    if (TICK_DIV <= 1) begin : g_every_clock
      assign tick_o = 1'b1;
    end else begin : g_divided
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] DLAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n)             div_q <= '0;
        else if (div_q == DLAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == DLAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_o <= 8'h00;
    else if (tick_o) cnt_o <= cnt_o + 8'd1;
  end

endmodule

// File: rtl/pwm_ramp_channel.sv
module pwm_ramp_channel
  import pwm_ramp_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int PRESC_LOG2 = 9,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [7:0]    pwm_cnt,
  input  logic          ld_we,
  input  logic [7:0]    ld_byte,
  output logic          pwm_o,
  output logic [7:0]    bright_o,
  output logic          dark_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] ld_ptr_o,
  output logic          step_evt_o,
  output logic          set_evt_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // Program loader: high byte latched, low byte commits the word.
  logic [15:0]   mem [DEPTH];
  logic [7:0]    hi_q;
  logic          phase_q;
  logic [AW-1:0] ptr_q;
  logic          commit;

  assign commit = !en && ld_we && phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= 8'h00;
      phase_q <= 1'b0;
      ptr_q   <= '0;
    end else if (en) begin
      phase_q <= 1'b0;
      ptr_q   <= '0;
    end else if (ld_we) begin
      if (!phase_q) begin
        hi_q    <= ld_byte;
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        ptr_q   <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[ptr_q] <= {hi_q, ld_byte};
  end

  // Sequencer
  logic [AW-1:0] pc_q;
  logic          busy_q;
  logic [6:0]    steps_q;
  logic [15:0]   wait_q;
  logic [7:0]    bright_q;
  logic          dark_q;
  logic [15:0]   instr;
  op_e           op;
  logic [AW-1:0] pc_next;
  logic          step_evt;

  always_comb begin
    instr    = mem[pc_q];
    op       = decode_op(instr);
    pc_next  = (pc_q == LAST) ? '0 : pc_q + 1'b1;
    step_evt = en && (op == OP_RAMP) && busy_q && tick && (wait_q == 16'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= '0;
      busy_q   <= 1'b0;
      steps_q  <= '0;
      wait_q   <= 16'd0;
      bright_q <= 8'h00;
      dark_q   <= 1'b0;
    end else if (!en) begin
      pc_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      unique case (op)
        OP_RESTART: pc_q <= '0;
        OP_JUMP:    pc_q <= instr[AW-1:0];
        OP_FORCE_OFF: begin
          bright_q <= 8'h00;
          dark_q   <= 1'b1;
          pc_q     <= pc_next;
        end
        OP_FORCE_ON: begin
          bright_q <= 8'hFF;
          dark_q   <= 1'b0;
          pc_q     <= pc_next;
        end
        OP_RAMP: begin
          if (!busy_q) begin
            if (instr[6:0] == 7'd0) begin
              pc_q <= pc_next;
            end else begin
              busy_q  <= 1'b1;
              steps_q <= instr[6:0];
              wait_q  <= step_ticks(instr, PRESC_LOG2);
            end
          end else if (tick) begin
            if (wait_q == 16'd1) begin
              bright_q <= sat_step(bright_q, instr[7]);
              dark_q   <= 1'b0;
              if (steps_q == 7'd1) begin
                busy_q <= 1'b0;
                pc_q   <= pc_next;
              end else begin
                steps_q <= steps_q - 7'd1;
                wait_q  <= step_ticks(instr, PRESC_LOG2);
              end
            end else begin
              wait_q <= wait_q - 16'd1;
            end
          end
        end
        default: pc_q <= pc_next;
      endcase
    end
  end

  // Registered compare output
  always_ff @(posedge clk) begin
    if (!rst_n) pwm_o <= 1'b0;
    else        pwm_o <= en && !dark_q && (bright_q >= pwm_cnt);
  end

  assign bright_o   = bright_q;
  assign dark_o     = dark_q;
  assign pc_o       = pc_q;
  assign ld_ptr_o   = ptr_q;
  assign step_evt_o = step_evt;
  assign set_evt_o  = en && ((op == OP_FORCE_OFF) || (op == OP_FORCE_ON));

endmodule

// File: rtl/pwm_ramp_engine.sv
module pwm_ramp_engine #(
  parameter int NCH        = 3,
  parameter int DEPTH      = 64,
  parameter int TICK_DIV   = 4,
  parameter int PRESC_LOG2 = 9,
  localparam int REG_AW    = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NCH-1:0]    pwm_out
);

  localparam int PC_AW = $clog2(DEPTH);

  logic                      tick;
  logic [7:0]                pwm_cnt;
  logic [NCH-1:0]            en_q;
  logic [NCH-1:0][7:0]       bright_w;
  logic [NCH-1:0]            dark_w;
  logic [NCH-1:0][PC_AW-1:0] pc_w;
  logic [NCH-1:0][PC_AW-1:0] ptr_w;
  logic [NCH-1:0]            step_w;
  logic [NCH-1:0]            set_w;

  always_ff @(posedge clk) begin
    if (!rst_n)                           en_q <= '0;
    else if (wr_en && wr_addr == '0)      en_q <= wr_data[NCH-1:0];
  end

  pwm_ramp_timebase #(.TICK_DIV(TICK_DIV)) u_timebase (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick),
    .cnt_o  (pwm_cnt)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic ld_we;
      assign ld_we = wr_en && (wr_addr == REG_AW'(c + 1));
      pwm_ramp_channel #(.DEPTH(DEPTH), .PRESC_LOG2(PRESC_LOG2)) u_ch (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q[c]),
        .tick       (tick),
        .pwm_cnt    (pwm_cnt),
        .ld_we      (ld_we),
        .ld_byte    (wr_data),
        .pwm_o      (pwm_out[c]),
        .bright_o   (bright_w[c]),
        .dark_o     (dark_w[c]),
        .pc_o       (pc_w[c]),
        .ld_ptr_o   (ptr_w[c]),
        .step_evt_o (step_w[c]),
        .set_evt_o  (set_w[c])
      );
    end
  endgenerate

endmodule

// File: rtl/pwm_ramp_checker.sv
module pwm_ramp_checker #(
  parameter int NCH = 3,
  parameter int AW  = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         en,
  input logic [NCH-1:0]         pwm_out,
  input logic [7:0]             pwm_cnt,
  input logic [NCH-1:0][7:0]    bright,
  input logic [NCH-1:0]         dark,
  input logic [NCH-1:0][AW-1:0] pc,
  input logic [NCH-1:0][AW-1:0] ld_ptr,
  input logic [NCH-1:0]         step_evt,
  input logic [NCH-1:0]         set_evt
);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chk
      assert_compare_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en[c] && !dark[c] && (bright[c] < pwm_cnt)) |=> !pwm_out[c]);

      assert_compare_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en[c] && !dark[c] && (bright[c] >= pwm_cnt)) |=> pwm_out[c]);

      assert_stopped_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en[c] |=> !pwm_out[c]);

      assert_pc_home_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en[c] |=> (pc[c] == '0));

      assert_level_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_evt[c] && !set_evt[c]) |=> $stable(bright[c]));

      assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_evt[c] |=> ((8'(bright[c] - $past(bright[c])) == 8'd1) ||
                         (8'($past(bright[c]) - bright[c]) == 8'd1) ||
                         $stable(bright[c])));

      assert_no_wrap_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_evt[c] && bright[c] == 8'hFF) |=> (bright[c] != 8'h00));

      assert_no_wrap_bottom_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_evt[c] && bright[c] == 8'h00) |=> (bright[c] != 8'hFF));

      assert_step_unblanks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_evt[c] |=> !dark[c]);

      assert_blank_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dark[c] |=> !pwm_out[c]);

      assert_full_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en[c] && !dark[c] && bright[c] == 8'hFF) |=> pwm_out[c]);

      assert_load_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en[c] |=> (ld_ptr[c] == '0));
    end
  endgenerate

endmodule

bind pwm_ramp_engine pwm_ramp_checker #(.NCH(NCH), .AW(PC_AW)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en_q),
  .pwm_out  (pwm_out),
  .pwm_cnt  (pwm_cnt),
  .bright   (bright_w),
  .dark     (dark_w),
  .pc       (pc_w),
  .ld_ptr   (ptr_w),
  .step_evt (step_w),
  .set_evt  (set_w)
);

// File: tb/test_pwm_ramp_engine.sv
`timescale 1ns/1ps
module test_pwm_ramp_engine;

  localparam int NCH = 3;
  localparam int TD  = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [1:0]     wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [NCH-1:0] ctrl_sh = '0;
  int mb [NCH];
  bit md [NCH];

  always #2.5 clk = ~clk;

  pwm_ramp_engine #(.NCH(NCH), .TICK_DIV(TD)) i_pwm_ramp_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  function automatic int exp_duty(input int b, input bit dk);
    return dk ? 0 : b + 1;
  endfunction

  function automatic int ramp_model(input int b, input bit down, input int n);
    int r = b;
    for (int i = 0; i < n; i++) begin
      if (down) r = (r > 0) ? r - 1 : 0;
      else      r = (r < 255) ? r + 1 : 255;
    end
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_en(input int ch, input bit v);
    ctrl_sh[ch] = v;
    wr(2'd0, {5'd0, ctrl_sh});
  endtask

  task automatic load(input int ch, input logic [15:0] w);
    wr(2'(ch + 1), w[15:8]);
    wr(2'(ch + 1), w[7:0]);
  endtask

  task automatic measure(input int ch, output int ticks);
    int n = 0;
    repeat (256 * TD) begin
      @(negedge clk);
      if (pwm_out[ch]) n++;
    end
    ticks = n / TD;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5ns * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int d;
    void'($urandom(32'd2024));
    for (int c = 0; c < NCH; c++) begin mb[c] = 0; md[c] = 0; end
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R9: reset state
    check("R9 outputs low after reset", int'(pwm_out), 0);
    measure(0, d);
    check("R9 disabled channel duty", d, 0);

    // R6/R7: force-on then hold via self-jump at word 1
    load(0, 16'h00FF); load(0, 16'hA001);
    set_en(0, 1'b1); idle(10);
    measure(0, d); mb[0] = 255; md[0] = 0;
    check("R6 force-on full duty (R7 two-word load)", d, 256);

    // R8: program writes while enabled are ignored
    load(0, 16'h007F);
    set_en(0, 1'b0); set_en(0, 1'b1); idle(10);
    measure(0, d);
    check("R8 load while enabled ignored", d, 256);

    // R2: clearing enable forces low
    set_en(0, 1'b0); idle(3);
    check("R2 output low after disable", int'(pwm_out[0]), 0);
    measure(0, d);
    check("R2 disabled duty zero", d, 0);

    // R6: force-off
    load(1, 16'h007F); load(1, 16'hA001);
    set_en(1, 1'b1); idle(10);
    measure(1, d); mb[1] = 0; md[1] = 1;
    check("R6 force-off zero duty", d, 0);

    // R3/R1: relative ramp up 5, then restart continues from last level (R2)
    load(2, 16'h0105); load(2, 16'hA001);
    set_en(2, 1'b1); idle(5 * TD + 20);
    measure(2, d); mb[2] = 5;
    check("R3 ramp up 5 from 0 (R1 duty=level+1)", d, exp_duty(mb[2], 0));
    set_en(2, 1'b0); set_en(2, 1'b1); idle(5 * TD + 20);
    measure(2, d); mb[2] = 10;
    check("R2 restart keeps level and reruns program", d, exp_duty(mb[2], 0));

    // R4: prescaled step time: 2 steps of 512 ticks each
    set_en(2, 1'b0);
    load(2, 16'h4102); load(2, 16'hA001);
    set_en(2, 1'b1); idle(4);
    measure(2, d);
    check("R4 prescaled ramp has not stepped yet", d, exp_duty(mb[2], 0));
    idle(1024 * TD);
    measure(2, d); mb[2] = 12;
    check("R4 prescaled ramp after two steps", d, exp_duty(mb[2], 0));

    // R5 + R3 saturation: ramp one step then restart at word 0, repeatedly
    set_en(1, 1'b0);
    load(1, 16'h0101); load(1, 16'h0000);
    set_en(1, 1'b1); idle(600 * TD);
    measure(1, d); mb[1] = 255; md[1] = 0;
    check("R5 restart word loops, R3 saturates at 0xFF", d, 256);
    set_en(1, 1'b0);
    load(1, 16'h0181); load(1, 16'h0000);
    set_en(1, 1'b1); idle(600 * TD);
    measure(1, d); mb[1] = 0;
    check("R3 down ramp saturates at 0x00", d, 1);

    // R5: jump to a non-zero target skips word 2
    load(0, 16'h00FF); load(0, 16'hA003); load(0, 16'h007F); load(0, 16'hA003);
    set_en(0, 1'b1); idle(10);
    measure(0, d); mb[0] = 255; md[0] = 0;
    check("R5 jump target skips force-off word", d, 256);
    set_en(0, 1'b0);

    // R3/R4 random ramps
    for (int it = 0; it < 16; it++) begin
      int ch  = $urandom_range(0, NCH - 1);
      bit dn  = 1'($urandom_range(0, 1));
      int st  = $urandom_range(0, 127);
      int tm  = $urandom_range(0, 3);
      int eff = (tm == 0) ? 1 : tm;
      logic [15:0] w;
      if (it == 0) st = 0;
      w = {1'b0, 1'b0, 6'(tm), dn, 7'(st)};
      if (w == 16'h0000 || w == 16'h007F || w == 16'h00FF) w[8] = 1'b1;
      eff = (w[13:8] == 6'd0) ? 1 : int'(w[13:8]);
      set_en(ch, 1'b0);
      load(ch, w); load(ch, 16'hA001);
      set_en(ch, 1'b1);
      idle(st * eff * TD + 40);
      measure(ch, d);
      mb[ch] = ramp_model(mb[ch], dn, st);
      if (st > 0) md[ch] = 0;
      check($sformatf("R3 random ramp it%0d ch%0d (R4 time %0d)", it, ch, eff),
            d, exp_duty(mb[ch], md[ch]));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule